// File: doc/BRIEF.md
# Memory Bit Manipulation Unit

This block carries out one single-bit or masked operation on a byte of memory for each accepted command. A command is made of an opcode, two operand bytes, the incoming carry, the accumulator value and a page select. The unit decodes the command, reads the byte it addresses through a request/acknowledge memory port and computes the result. Depending on the opcode it then writes the modified byte back, updates the carry, or updates the negative and zero flags. Instruction fetch, operand fetch and the register file belong to the surrounding processor. The processor hands the command over with a one-cycle `start` pulse and collects the results when `done` pulses.

Control is a four-state machine. `S_IDLE` waits for `start`. `S_READ` holds a read request until it is acknowledged. `S_WRITE` holds the write-back request until it is acknowledged. `S_DONE` pulses `done` for one cycle. The transitions are:
- accept-to-read: `S_IDLE` or `S_DONE` goes to `S_READ` on `start` with a supported opcode.
- accept-to-done: `S_IDLE` or `S_DONE` goes to `S_DONE` on `start` with an unsupported opcode.
- read-to-write: `S_READ` goes to `S_WRITE` on acknowledge for a modifying operation.
- read-to-done: `S_READ` goes to `S_DONE` on acknowledge for a carry-only operation.
- write-to-done: `S_WRITE` goes to `S_DONE` on acknowledge.
- done-to-idle: `S_DONE` goes to `S_IDLE` when no new `start` arrives.

A new command may be accepted in the same cycle as `done`.

Top module: `bitop_unit`

## Requirements
- R1: After reset, `ready` is 1 and `done`, `mem_req`, `mem_we`, `carry_out`, `neg_out` and `zero_out` are all 0.
- R2: For opcodes whose low nibble is 0xA, the bit index is `opnd_hi[7:5]`. The 16-bit address is zero-extended from the 13-bit value `{opnd_hi[4:0], opnd_lo}`.
- R3: The six carry opcodes read the byte and set the carry from the indexed bit b, starting from `carry_in` c. 0xAA gives b, 0x4A gives c&b, 0x0A gives c|b, 0x6A gives c&~b, 0x2A gives c|~b and 0x8A gives c^b.
- R4: A carry opcode (R3) makes exactly one read and no write.
- R5: Opcode 0xCA reads the byte, replaces the indexed bit with `carry_in` and writes the byte back. All other bits are unchanged and the carry is unchanged.
- R6: Opcode 0xEA reads the byte, inverts the indexed bit and writes the byte back.
- R7: Any opcode whose low nibble is 0x2 is a page bit operation. The bit index is `opcode[7:5]`. `opcode[4]`=1 clears the bit and 0 sets it. The address is `{page_sel, opnd_lo}` zero-extended, which is 0x00nn or 0x01nn.
- R8: Opcode 0x0E writes mem|A and opcode 0x4E writes mem&~A, both at address `{opnd_hi, opnd_lo}`. Both set `neg_out` to bit 7 and `zero_out` to (value==0) of the 8-bit difference A minus mem. Both leave the carry at `carry_in`. No other opcode changes `neg_out` or `zero_out`.
- R9: Every modifying operation issues one read followed by one write to the same address. `mem_req` and `mem_addr` hold steady until `mem_ack`.
- R10: `done` is high for the single cycle after the final acknowledge. `ready` is high in the idle and done states, and `start` is accepted in either of them.
- R11: An unsupported opcode (for example 0x00, 0xFF or 0x1A) makes no memory access. `done` follows one cycle after acceptance and `carry_out` equals `carry_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command valid, taken when `ready` is 1 |
| opcode | input | 8 | Operation code |
| opnd_lo | input | 8 | First operand byte |
| opnd_hi | input | 8 | Second operand byte |
| carry_in | input | 1 | Carry flag before the operation |
| acc_in | input | 8 | Accumulator mask for the test operations |
| page_sel | input | 1 | Page select for page bit operations |
| ready | output | 1 | Unit can take a command this cycle |
| done | output | 1 | One-cycle completion pulse |
| carry_out | output | 1 | Carry after the operation |
| neg_out | output | 1 | Negative flag from the test operations |
| zero_out | output | 1 | Zero flag from the test operations |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid with it |
| mem_rdata | input | 8 | Read data |

## Verification
The completion pulse of one command and the acceptance of the next command can fall in the same cycle. The bench provokes this by raising `start` exactly in the cycle where `done` is seen high. It does this in a chain that mixes modifying, carry-only and unsupported opcodes. A behavioural model in the bench predicts every memory transaction and every result in program order. The bench judges the overlap by three things: each transaction of the second command matches the model, the `done` of the first command still carries its own flags, and no idle cycle is inserted between the two commands.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    typedef enum logic [3:0] {
        K_NONE,
        K_C_LD,
        K_C_AND,
        K_C_OR,
        K_C_ANDN,
        K_C_ORN,
        K_C_XOR,
        K_B_ST,
        K_B_NOT,
        K_PG_SET,
        K_PG_CLR,
        K_T_SET,
        K_T_CLR
    } kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_READ,
        S_WRITE,
        S_DONE
    } state_e;

    function automatic logic carry_only(input kind_e k);
        return (k == K_C_LD) || (k == K_C_AND) || (k == K_C_OR) ||
               (k == K_C_ANDN) || (k == K_C_ORN) || (k == K_C_XOR);
    endfunction

    function automatic logic is_test(input kind_e k);
        return (k == K_T_SET) || (k == K_T_CLR);
    endfunction

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
    import bitop_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3,
    parameter int ADDR_W = 16,
    parameter int OPC_W  = 8
) (
    input  logic [OPC_W-1:0]  opcode,
    input  logic [DATA_W-1:0] opnd_lo,
    input  logic [DATA_W-1:0] opnd_hi,
    input  logic              page_sel,
    output kind_e             kind,
    output logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    localparam int HI_ADDR_W = DATA_W - IDX_W;

    logic [ADDR_W-1:0] abs_addr;
    logic [ADDR_W-1:0] full_addr;
    logic [ADDR_W-1:0] page_addr;

    always_comb begin
        abs_addr  = ADDR_W'({opnd_hi[HI_ADDR_W-1:0], opnd_lo});
        full_addr = ADDR_W'({opnd_hi, opnd_lo});
        page_addr = ADDR_W'({page_sel, opnd_lo});
    end

    always_comb begin
        kind = K_NONE;
        addr = '0;
        idx  = '0;
        case (opcode[3:0])
            4'hA: begin
                // absolute bit forms: index in the top of the second operand
                idx  = opnd_hi[DATA_W-1 -: IDX_W];
                addr = abs_addr;
                case (opcode[7:4])
                    4'h0:    kind = K_C_OR;
                    4'h2:    kind = K_C_ORN;
                    4'h4:    kind = K_C_AND;
                    4'h6:    kind = K_C_ANDN;
                    4'h8:    kind = K_C_XOR;
                    4'hA:    kind = K_C_LD;
                    4'hC:    kind = K_B_ST;
                    4'hE:    kind = K_B_NOT;
                    default: kind = K_NONE;
                endcase
            end
            4'h2: begin
                // page bit forms: index and polarity from the opcode
                idx  = opcode[OPC_W-1 -: IDX_W];
                addr = page_addr;
                kind = opcode[4] ? K_PG_CLR : K_PG_SET;
            end
            4'hE: begin
                addr = full_addr;
                if (opcode[7:4] == 4'h0)
                    kind = K_T_SET;
                else if (opcode[7:4] == 4'h4)
                    kind = K_T_CLR;
                else
                    kind = K_NONE;
            end
            default: kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
    import bitop_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  kind_e             kind,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] acc,
    input  logic              carry,
    output logic [DATA_W-1:0] wdata,
    output logic              carry_new,
    output logic              n_new,
    output logic              z_new
);
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] diff;
    logic              bit_v;

    always_comb begin
        mask       = '0;
        mask[idx]  = 1'b1;
        bit_v      = rdata[idx];
        diff       = acc - rdata;
        n_new      = diff[DATA_W-1];
        z_new      = (diff == '0);
        wdata      = rdata;
        carry_new  = carry;
        case (kind)
            K_C_LD:   carry_new = bit_v;
            K_C_AND:  carry_new = carry & bit_v;
            K_C_OR:   carry_new = carry | bit_v;
            K_C_ANDN: carry_new = carry & ~bit_v;
            K_C_ORN:  carry_new = carry | ~bit_v;
            K_C_XOR:  carry_new = carry ^ bit_v;
            K_B_ST:   wdata = (rdata & ~mask) | (carry ? mask : '0);
            K_B_NOT:  wdata = rdata ^ mask;
            K_PG_SET: wdata = rdata | mask;
            K_PG_CLR: wdata = rdata & ~mask;
            K_T_SET:  wdata = rdata | acc;
            K_T_CLR:  wdata = rdata & ~acc;
            default:  wdata = rdata;
        endcase
    end

    // R5 R6 R7: single-bit operations touch at most one bit of the byte
    p_one_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_B_ST || kind == K_B_NOT || kind == K_PG_SET || kind == K_PG_CLR)
        |-> ($countones(wdata ^ rdata) <= 1));
endmodule

// File: rtl/bitop_fsm.sv
module bitop_fsm
    import bitop_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  kind_e kind_d,
    input  kind_e kind_q,
    input  logic  mem_ack,
    output logic  accept,
    output logic  take_read,
    output logic  ready,
    output logic  done,
    output logic  mem_req,
    output logic  mem_we
);
    state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE, S_DONE: begin
                if (start)
                    state_nx = (kind_d == K_NONE) ? S_DONE : S_READ;
                else
                    state_nx = S_IDLE;
            end
            S_READ: begin
                if (mem_ack)
                    state_nx = carry_only(kind_q) ? S_DONE : S_WRITE;
            end
            S_WRITE: begin
                if (mem_ack)
                    state_nx = S_DONE;
            end
        endcase
    end

    always_comb begin
        ready     = (state == S_IDLE) || (state == S_DONE);
        accept    = ready && start;
        done      = (state == S_DONE);
        mem_req   = (state == S_READ) || (state == S_WRITE);
        mem_we    = (state == S_WRITE);
        take_read = (state == S_READ) && mem_ack;
    end

    // R9: a write is only ever entered straight from an acknowledged read
    p_rmw_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> $past(take_read));

    // R9: an unanswered request stays up
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req);

    // R4: carry-only operations never write
    p_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !carry_only(kind_q));

    // R10 R11: done follows an acknowledge or an unsupported acceptance
    p_done_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(mem_ack) || $past(accept && kind_d == K_NONE)));
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [7:0]            opcode,
    input  logic [DATA_W-1:0]     opnd_lo,
    input  logic [DATA_W-1:0]     opnd_hi,
    input  logic                  carry_in,
    input  logic [DATA_W-1:0]     acc_in,
    input  logic                  page_sel,
    output logic                  ready,
    output logic                  done,
    output logic                  carry_out,
    output logic                  neg_out,
    output logic                  zero_out,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [2*DATA_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]     mem_wdata,
    input  logic                  mem_ack,
    input  logic [DATA_W-1:0]     mem_rdata
);
    localparam int IDX_W  = $clog2(DATA_W);
    localparam int ADDR_W = 2 * DATA_W;
    localparam int OPC_W  = 8;

    kind_e             kind_d, kind_q;
    logic [ADDR_W-1:0] addr_d, addr_q;
    logic [IDX_W-1:0]  idx_d, idx_q;
    logic [DATA_W-1:0] acc_q, wdata_q, alu_w;
    logic              carry_q, neg_q, zero_q;
    logic              alu_c, alu_n, alu_z;
    logic              accept, take_read;

    bitop_decode #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .ADDR_W (ADDR_W),
        .OPC_W  (OPC_W)
    ) i_decode (
        .opcode   (opcode),
        .opnd_lo  (opnd_lo),
        .opnd_hi  (opnd_hi),
        .page_sel (page_sel),
        .kind     (kind_d),
        .addr     (addr_d),
        .idx      (idx_d)
    );

    bitop_alu #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) i_alu (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind_q),
        .idx       (idx_q),
        .rdata     (mem_rdata),
        .acc       (acc_q),
        .carry     (carry_q),
        .wdata     (alu_w),
        .carry_new (alu_c),
        .n_new     (alu_n),
        .z_new     (alu_z)
    );

    bitop_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .kind_d    (kind_d),
        .kind_q    (kind_q),
        .mem_ack   (mem_ack),
        .accept    (accept),
        .take_read (take_read),
        .ready     (ready),
        .done      (done),
        .mem_req   (mem_req),
        .mem_we    (mem_we)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= K_NONE;
            addr_q  <= '0;
            idx_q   <= '0;
            acc_q   <= '0;
            wdata_q <= '0;
            carry_q <= 1'b0;
            neg_q   <= 1'b0;
            zero_q  <= 1'b0;
        end else if (accept) begin
            kind_q  <= kind_d;
            addr_q  <= addr_d;
            idx_q   <= idx_d;
            acc_q   <= acc_in;
            carry_q <= carry_in;
        end else if (take_read) begin
            wdata_q <= alu_w;
            if (carry_only(kind_q))
                carry_q <= alu_c;
            if (is_test(kind_q)) begin
                neg_q  <= alu_n;
                zero_q <= alu_z;
            end
        end
    end

    always_comb begin
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
        carry_out = carry_q;
        neg_out   = neg_q;
        zero_out  = zero_q;
    end

    // R9: the address does not move while a request waits
    p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> $stable(mem_addr));

    // R8: flags move only when a test operation's read completes
    p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(take_read && is_test(kind_q)) |=> $stable({neg_out, zero_out}));

    // R5 R8: modifying operations leave the accepted carry alone
    p_carry_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_read && !carry_only(kind_q)) |=> $stable(carry_out));
endmodule

// File: tb/test_bitop_unit.sv
module test_bitop_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0, opnd_lo = '0, opnd_hi = '0, acc_in = '0;
    logic        carry_in = 1'b0, page_sel = 1'b0;
    logic        ready, done, carry_out, neg_out, zero_out, mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;

    always #10 clk = ~clk;

    bitop_unit i_bitop_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .carry_in(carry_in),
        .acc_in(acc_in), .page_sel(page_sel), .ready(ready), .done(done),
        .carry_out(carry_out), .neg_out(neg_out), .zero_out(zero_out),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0, wait_cfg = 0, wcnt = 0, last_ack = 0;
    bit finished = 0;
    logic [7:0]  dev [int];
    logic [7:0]  sh  [int];
    logic [24:0] q_txn [$];
    logic [2:0]  q_res [$];
    bit          q_none [$];
    int          q_icyc [$];
    logic        mdl_n = 1'b0, mdl_z = 1'b0;

    function automatic logic [7:0] dflt(input int a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction
    function automatic logic [7:0] dev_rd(input int a);
        return dev.exists(a) ? dev[a] : dflt(a);
    endfunction
    function automatic logic [7:0] sh_rd(input int a);
        return sh.exists(a) ? sh[a] : dflt(a);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic set_mem(input int a, input logic [7:0] v);
        dev[a] = v;
        sh[a]  = v;
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // memory responder and per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
            wcnt = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
            wcnt = 0;
        end else if (mem_req) begin
            if (wcnt >= wait_cfg) begin
                logic [24:0] e;
                mem_ack = 1'b1;
                mem_rdata = dev_rd(int'(mem_addr));
                last_ack = cyc;
                if (q_txn.size() == 0) begin
                    chk("R4/R9 unexpected transaction", {7'd0, mem_we, mem_addr, 8'h00}, 32'hFFFF_FFFF);
                end else begin
                    e = q_txn.pop_front();
                    chk("R2/R7/R9 transaction", {7'd0, mem_we, mem_addr, mem_we ? mem_wdata : 8'h00}, {7'd0, e});
                end
                if (mem_we) dev[int'(mem_addr)] = mem_wdata;
            end else begin
                wcnt++;
            end
        end
        if (rst_n && done) begin
            if (q_res.size() == 0) begin
                chk("R10 spurious done", 32'd1, 32'd0);
            end else begin
                logic [2:0] r;
                bit nn;
                int ic;
                r  = q_res.pop_front();
                nn = q_none.pop_front();
                ic = q_icyc.pop_front();
                chk("R3/R11 carry_out", {31'd0, carry_out}, {31'd0, r[2]});
                chk("R8 neg_out", {31'd0, neg_out}, {31'd0, r[1]});
                chk("R8 zero_out", {31'd0, zero_out}, {31'd0, r[0]});
                chk("R10 ready with done", {31'd0, ready}, 32'd1);
                if (nn) chk("R11 done timing", cyc, ic + 1);
                else    chk("R10 done timing", cyc, last_ack + 1);
            end
        end
    end

    task automatic issue(input logic [7:0] opc, input logic [7:0] lo, input logic [7:0] hi,
                         input logic c, input logic [7:0] a, input logic pg);
        int ad, ix;
        logic [7:0] m, w, d;
        logic nc, rd, wr;
        nc = c; rd = 1'b1; wr = 1'b0; ad = 0; ix = 0; m = '0; w = '0;
        if (opc[3:0] == 4'hA) begin
            ad = int'({hi[4:0], lo});
            ix = int'(hi[7:5]);
            m  = sh_rd(ad);
            case (opc[7:4])
                4'h0: nc = c | m[ix];
                4'h2: nc = c | ~m[ix];
                4'h4: nc = c & m[ix];
                4'h6: nc = c & ~m[ix];
                4'h8: nc = c ^ m[ix];
                4'hA: nc = m[ix];
                4'hC: begin w = m; w[ix] = c; wr = 1'b1; end
                4'hE: begin w = m; w[ix] = ~m[ix]; wr = 1'b1; end
                default: rd = 1'b0;
            endcase
        end else if (opc[3:0] == 4'h2) begin
            ad = int'({pg, lo});
            ix = int'(opc[7:5]);
            m  = sh_rd(ad);
            w  = m;
            w[ix] = ~opc[4];
            wr = 1'b1;
        end else if (opc == 8'h0E || opc == 8'h4E) begin
            ad = int'({hi, lo});
            m  = sh_rd(ad);
            w  = (opc == 8'h0E) ? (m | a) : (m & ~a);
            d  = a - m;
            mdl_n = d[7];
            mdl_z = (d == 8'h00);
            wr = 1'b1;
        end else begin
            rd = 1'b0;
        end
        if (rd) q_txn.push_back({1'b0, ad[15:0], 8'h00});
        if (wr) begin
            q_txn.push_back({1'b1, ad[15:0], w});
            sh[ad] = w;
        end
        q_res.push_back({nc, mdl_n, mdl_z});
        q_none.push_back(!rd);
        q_icyc.push_back(cyc);
        opcode = opc; opnd_lo = lo; opnd_hi = hi; carry_in = c; acc_in = a; page_sel = pg;
        start = 1'b1;
    endtask

    task automatic run_op(input logic [7:0] opc, input logic [7:0] lo, input logic [7:0] hi,
                          input logic c, input logic [7:0] a, input logic pg);
        while (!ready) @(negedge clk);
        issue(opc, lo, hi, c, a, pg);
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        wait_cfg = (wait_cfg + 1) % 3;
    endtask

    initial begin
        logic [7:0] cops [6];
        cops = '{8'h0A, 8'h2A, 8'h4A, 8'h6A, 8'h8A, 8'hAA};
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ready", {31'd0, ready}, 32'd1);
        chk("R1 quiet outputs", {26'd0, done, mem_req, mem_we, carry_out, neg_out, zero_out}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: 13-bit absolute address and index from the top bits
        set_mem(16'h1F34, 8'h80);
        run_op(8'hAA, 8'h34, 8'hFF, 1'b0, 8'h00, 1'b0);
        set_mem(16'h0534, 8'h01);
        run_op(8'hAA, 8'h34, 8'h05, 1'b0, 8'h00, 1'b1);

        // R3 R4: six carry functions, both carry values, both bit values
        for (int i = 0; i < 6; i++)
            for (int c = 0; c < 2; c++)
                for (int b = 0; b < 2; b++) begin
                    int ix;
                    logic [7:0] lo, v;
                    ix = (i + 2 * c + b) % 8;
                    lo = 8'(i * 4 + c * 2 + b);
                    v  = 8'hA5;
                    v[ix] = b[0];
                    set_mem(int'({5'h0A, lo}), v);
                    run_op(cops[i], lo, {3'(ix), 5'h0A}, c[0], 8'h00, 1'b0);
                end

        // R5: carry store to a bit, both polarities
        for (int k = 0; k < 8; k++)
            run_op(8'hCA, 8'(8'h40 + k), {3'(k), 5'h03}, k[0], 8'h00, 1'b0);

        // R6: toggle twice returns the byte
        run_op(8'hEA, 8'h77, 8'h47, 1'b1, 8'h00, 1'b0);
        run_op(8'hEA, 8'h77, 8'h47, 1'b0, 8'h00, 1'b0);

        // R7: page bit set and clear, all bits, both pages
        for (int p = 0; p < 2; p++)
            for (int k = 0; k < 8; k++) begin
                run_op({3'(k), 1'b0, 4'h2}, 8'h90, 8'hEE, 1'b0, 8'h00, p[0]);
                run_op({3'(k), 1'b1, 4'h2}, 8'h91, 8'hEE, 1'b1, 8'h00, p[0]);
            end

        // R8: test-and-set / test-and-clear with equal, smaller, larger mask
        set_mem(16'h2345, 8'h3C);
        run_op(8'h0E, 8'h45, 8'h23, 1'b1, 8'h3C, 1'b0);
        set_mem(16'h2346, 8'h50);
        run_op(8'h4E, 8'h46, 8'h23, 1'b0, 8'h10, 1'b0);
        set_mem(16'hBEEF, 8'h01);
        run_op(8'h0E, 8'hEF, 8'hBE, 1'b0, 8'h81, 1'b1);
        run_op(8'hAA, 8'h10, 8'h20, 1'b1, 8'h00, 1'b0); // R8: flags held

        // R11: unsupported opcodes
        run_op(8'h00, 8'h12, 8'h34, 1'b1, 8'hFF, 1'b0);
        run_op(8'hFF, 8'h12, 8'h34, 1'b0, 8'hFF, 1'b1);
        run_op(8'h1A, 8'h12, 8'h34, 1'b1, 8'h00, 1'b0);

        // R10: next start in the cycle of done, mixed chain
        while (!ready) @(negedge clk);
        wait_cfg = 0;
        issue(8'hEA, 8'h05, 8'h61, 1'b0, 8'h00, 1'b0);
        @(negedge clk); start = 1'b0;
        while (!done) @(negedge clk);
        issue(8'h8A, 8'h05, 8'h61, 1'b1, 8'h00, 1'b0);
        @(negedge clk); start = 1'b0;
        while (!done) @(negedge clk);
        issue(8'h00, 8'h00, 8'h00, 1'b1, 8'h00, 1'b0);
        @(negedge clk); start = 1'b0;
        while (!done) @(negedge clk);
        issue(8'h4E, 8'h05, 8'h01, 1'b0, 8'hFF, 1'b0);
        @(negedge clk); start = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);

        chk("R9 all transactions seen", q_txn.size(), 32'd0);
        chk("R10 all completions seen", q_res.size(), 32'd0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule